// File: doc/BRIEF.md
# Integer/Fractional Frame Rate Detector

The detector decides whether a recovered receive clock runs at an integer video rate (for example 148.5 or 74.25 MHz) or at the matching fractional rate, which is the integer rate scaled by 1/1.001 (148.35 or 74.175 MHz). It compares the recovered clock with a local core clock. The two clocks are assumed to share a nominal base frequency and to differ, if at all, only by the 1/1.001 factor. A static configuration input states whether the core clock itself is integer rate (0) or fractional rate (1).

A free-running counter in the recovered domain is gray coded and synchronised into the core domain. The core domain measures how many recovered cycles pass during each window of 2^WIN_LOG2 core cycles. If that count lies within a tolerance of the window length, the recovered clock belongs to the same family as the core clock. Otherwise it belongs to the other family. The result flag is updated only at a window boundary, and a one-cycle valid strobe marks each update.

Top module: `frac_rate_detect`

## Requirements
- R1: While reset is high and after it is released, `rate_is_frac` reads 0 and `rate_valid` reads 0 until the first evaluation.
- R2: With `core_is_frac`=0 and the recovered clock at the same frequency as the core clock, each evaluation gives `rate_is_frac`=0.
- R3: With `core_is_frac`=0 and the recovered clock slower by the factor 1/1.001, each evaluation gives `rate_is_frac`=1.
- R4: With `core_is_frac`=1 and the recovered clock at the same frequency as the core clock, each evaluation gives `rate_is_frac`=1.
- R5: With `core_is_frac`=1 and the recovered clock faster by the factor 1.001, each evaluation gives `rate_is_frac`=0.
- R6: The clocks count as the same family when the recovered count per window differs from 2^WIN_LOG2 by at most floor(2^WIN_LOG2/2000). A deviation of 200 ppm in either direction is therefore judged as the same family.
- R7: `rate_valid` is high for exactly one core cycle per window of 2^WIN_LOG2 core cycles. After the first core edge with reset low, the first pulse follows core edge 2*2^WIN_LOG2, because the first window only records a starting count. Later pulses follow every multiple of 2^WIN_LOG2.
- R8: `rate_is_frac` changes only in a cycle in which `rate_valid` is high.
- R9: For steady inputs, successive evaluations give the same flag. The count crosses between the domains without corruption: the gray value changes by at most one bit per recovered cycle, and the synchronised count advances by at most 2 per core cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Local core clock; reference for the window |
| rst | input | 1 | Synchronous active-high reset, core domain |
| core_is_frac | input | 1 | Static: 0 = core clock integer rate, 1 = fractional rate |
| rec_clk | input | 1 | Recovered receive clock under test |
| rate_is_frac | output | 1 | 0 = recovered clock integer rate, 1 = fractional rate |
| rate_valid | output | 1 | One-cycle strobe when the flag is re-evaluated |

## Verification
A corrupt window counter moves the valid strobe off its grid of 2^WIN_LOG2 core cycles, and the per-cycle comparison against the expected pulse position catches this at the very next boundary. A wrong stored starting count, a wrong tolerance or a broken crossing shows as a wrong flag at the first evaluation after a change of stimulus. The stimuli place the rate difference at about twice the tolerance, or at half of it, so that such faults are exposed. A flag that changes outside a strobe is caught in the cycle in which it moves.

// File: rtl/frd_pkg.sv
`timescale 1ns/1fs
package frd_pkg;

    typedef enum logic {
        RATE_INT  = 1'b0,
        RATE_FRAC = 1'b1
    } rate_e;

    typedef struct packed {
        logic  valid;
        rate_e rate;
    } verdict_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Same family as the core clock keeps the core family; otherwise flip it.
    function automatic rate_e resolve(input rate_e core_fam, input logic same);
        return same ? core_fam : rate_e'(~core_fam);
    endfunction

endpackage

// File: rtl/frd_rec_count.sv
`timescale 1ns/1fs
module frd_rec_count
    import frd_pkg::*;
#(
    parameter int CW = 18
) (
    input  logic          rec_clk,
    input  logic          rst,
    output logic [CW-1:0] gray_o
);

    logic [1:0]    rsync;
    logic          rrst;
    logic [CW-1:0] cnt;

    always_ff @(posedge rec_clk) begin
        rsync <= {rsync[0], rst};
    end
    assign rrst = rsync[1];

    always_ff @(posedge rec_clk) begin
        if (rrst) begin
            cnt    <= '0;
            gray_o <= '0;
        end else begin
            cnt    <= cnt + 1'b1;
            gray_o <= CW'(bin2gray(32'(cnt)));
        end
    end

    // R9
    gray_step_chk: assert property (@(posedge rec_clk) disable iff (rrst)
        $countones(gray_o ^ $past(gray_o)) <= 1);

endmodule

// File: rtl/frd_gray_sync.sv
`timescale 1ns/1fs
module frd_gray_sync
    import frd_pkg::*;
#(
    parameter int CW     = 18,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] bin_o
);

    logic [CW-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= gray_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign bin_o = CW'(gray2bin(32'(stage[STAGES-1])));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        CW'(bin_o - $past(bin_o)) <= CW'(2));

endmodule

// File: rtl/frd_judge.sv
`timescale 1ns/1fs
module frd_judge
    import frd_pkg::*;
#(
    parameter int WIN_LOG2 = 16,
    parameter int CW       = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_is_frac,
    input  logic [CW-1:0] rec_count,
    output rate_e         rate,
    output logic          rate_valid
);

    localparam int WIN = 1 << WIN_LOG2;
    localparam int TOL = WIN / 2000;

    logic [WIN_LOG2-1:0] wcnt;
    logic                primed;
    logic [CW-1:0]       mark;
    logic [CW-1:0]       delta;
    int                  dev;
    logic                same;
    verdict_t            v;

    always_comb begin
        delta = rec_count - mark;
        dev   = int'(delta) - WIN;
        same  = (dev <= TOL) && (dev >= -TOL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt   <= '0;
            primed <= 1'b0;
            mark   <= '0;
            v      <= '{valid: 1'b0, rate: RATE_INT};
        end else begin
            wcnt    <= wcnt + 1'b1;
            v.valid <= 1'b0;
            if (&wcnt) begin
                mark   <= rec_count;
                primed <= 1'b1;
                if (primed) begin
                    v.valid <= 1'b1;
                    v.rate  <= resolve(rate_e'(core_is_frac), same);
                end
            end
        end
    end

    assign rate       = v.rate;
    assign rate_valid = v.valid;

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        rate_valid |=> !rate_valid);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rate != $past(rate)) |-> rate_valid);

endmodule

// File: rtl/frac_rate_detect.sv
`timescale 1ns/1fs
module frac_rate_detect
    import frd_pkg::*;
#(
    parameter int WIN_LOG2    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic core_clk,
    input  logic rst,
    input  logic core_is_frac,
    input  logic rec_clk,
    output logic rate_is_frac,
    output logic rate_valid
);

    localparam int CW = WIN_LOG2 + 2;

    logic [CW-1:0] rec_gray;
    logic [CW-1:0] rec_bin;
    rate_e         rate;

    frd_rec_count #(.CW(CW)) u_rec (
        .rec_clk (rec_clk),
        .rst     (rst),
        .gray_o  (rec_gray)
    );

    frd_gray_sync #(.CW(CW), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (core_clk),
        .rst    (rst),
        .gray_i (rec_gray),
        .bin_o  (rec_bin)
    );

    frd_judge #(.WIN_LOG2(WIN_LOG2), .CW(CW)) u_judge (
        .clk          (core_clk),
        .rst          (rst),
        .core_is_frac (core_is_frac),
        .rec_count    (rec_bin),
        .rate         (rate),
        .rate_valid   (rate_valid)
    );

    assign rate_is_frac = (rate == RATE_FRAC);

    // R1
    reset_quiet_chk: assert property (@(posedge core_clk)
        $past(rst) |-> (!rate_valid && !rate_is_frac));

endmodule

// File: tb/tb_frac_rate_detect.sv
`timescale 1ns/1fs
module tb_frac_rate_detect;

    localparam int WIN_LOG2 = 13;
    localparam int WIN      = 1 << WIN_LOG2;

    logic core_clk = 1'b0;
    logic rec_clk  = 1'b0;
    logic rst      = 1'b1;
    logic core_is_frac = 1'b0;
    logic rate_is_frac;
    logic rate_valid;

    real   rec_half = 2.5;
    int    checks = 0;
    int    failures = 0;
    int    edges = 0;
    int    cyc = 0;
    int    skip = 0;
    logic  exp_flag = 1'b0;
    logic  prev_flag = 1'b0;
    logic  done = 1'b0;
    string cur_req = "R2";

    frac_rate_detect #(.WIN_LOG2(WIN_LOG2), .SYNC_STAGES(2)) dut (
        .core_clk     (core_clk),
        .rst          (rst),
        .core_is_frac (core_is_frac),
        .rec_clk      (rec_clk),
        .rate_is_frac (rate_is_frac),
        .rate_valid   (rate_valid)
    );

    always #2.5 core_clk = ~core_clk;
    always #(rec_half) rec_clk = ~rec_clk;

    always @(posedge core_clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
        cyc <= cyc + 1;
        if (cyc == 190000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual cycles=%0d expected completion before that", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Behavioural reference compared at every falling edge
    always @(negedge core_clk) begin
        if (rst) begin
            if (cyc > 2) begin
                checks++;
                if (rate_valid !== 1'b0 || rate_is_frac !== 1'b0) begin
                    failures++;
                    $display("FAIL R1: valid=%b flag=%b expected 0/0 in reset", rate_valid, rate_is_frac);
                end
            end
        end else begin
            logic exp_valid;
            exp_valid = (edges >= 2*WIN) && (edges % WIN == 0);
            checks++;
            if (rate_valid !== exp_valid) begin
                failures++;
                $display("FAIL R7: valid=%b expected %b at edge %0d", rate_valid, exp_valid, edges);
            end
            checks++;
            if (rate_is_frac !== prev_flag && rate_valid !== 1'b1) begin
                failures++;
                $display("FAIL R8: flag moved %b->%b expected no change without valid", prev_flag, rate_is_frac);
            end
            if (edges < 2*WIN) begin
                checks++;
                if (rate_is_frac !== 1'b0) begin
                    failures++;
                    $display("FAIL R1: flag=%b expected 0 before first evaluation", rate_is_frac);
                end
            end
            if (rate_valid === 1'b1) begin
                if (skip > 0) begin
                    skip--;
                end else begin
                    checks++;
                    if (rate_is_frac !== exp_flag) begin
                        failures++;
                        $display("FAIL %s: flag=%b expected %b", cur_req, rate_is_frac, exp_flag);
                    end
                end
            end
        end
        prev_flag = rate_is_frac;
    end

    task automatic wait_valid();
        do @(negedge core_clk); while (rate_valid !== 1'b1);
    endtask

    task automatic apply(input logic cfg, input real half, input logic expv, input string req);
        @(posedge core_clk);
        #1;
        core_is_frac = cfg;
        rec_half     = half;
        exp_flag     = expv;
        cur_req      = req;
        skip         = 1;
    endtask

    initial begin
        repeat (10) @(negedge core_clk);
        rst = 1'b0;
        // R2: same family, integer core
        wait_valid();
        cur_req = "R9";
        wait_valid();
        // R3: recovered slower by 1/1.001
        apply(1'b0, 2.5025, 1'b1, "R3");
        wait_valid(); wait_valid();
        // R6: 200 ppm slow still same family
        apply(1'b0, 2.5005, 1'b0, "R6");
        wait_valid(); wait_valid();
        // R4: fractional core, same rate
        apply(1'b1, 2.5, 1'b1, "R4");
        wait_valid(); wait_valid();
        // R5: fractional core, recovered faster by 1.001
        apply(1'b1, 2.4975, 1'b0, "R5");
        wait_valid(); wait_valid();
        cur_req = "R9";
        wait_valid();
        // R6: 200 ppm fast still same family
        apply(1'b1, 2.4995, 1'b1, "R6");
        wait_valid(); wait_valid();
        done = 1'b1;
        @(posedge core_clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule